// File: doc/BRIEF.md
# Parallel I/O peripheral bus front end

This block sits between an 8-bit CPU bus with separate I/O cycles and the inside of a two-port parallel I/O peripheral. It samples the active-low bus strobes (chip enable, I/O request, read, first machine cycle) together with two address lines on every rising clock edge. One line picks port A or port B. The other picks the data or the control register of that port. From these samples it produces one-cycle read and write strobes for the four internal registers and captures write data. During reads it drives the data bus through a separate output value and output enable.

The block also watches the first-machine-cycle strobe for a reset condition. A long low level on that strobe, seen while no I/O request and no read is active, clears the internal state. The block also forms the interrupt priority chain: an enable coming from the higher-priority neighbour is passed on to the lower-priority neighbour only while no local request is pending. An interrupt acknowledge is granted only while the incoming enable is high. The real port logic is reduced to four plain registers, and the local request comes in on a single request input.

Top module: `pbf_front`

## Requirements
- R1: The target index is {port_sel, ctl_sel}: 0 is port A data, 1 is port A control, 2 is port B data, 3 is port B control. Bit n of `rd_stb`/`wr_stb` and byte n of `regs_o` (bits 8n+7..8n) belong to index n.
- R2: While `cs_n` is sampled high, no register changes, `rd_stb` and `wr_stb` stay zero and `data_oe` stays low.
- R3: When `cs_n`, `iorq_n` and `rd_n` are sampled low and `m1_n` high, `data_oe` is high and `data_o` holds the selected register, from the second rising edge after the strobes were applied. At the same edge `rd_stb` pulses for one cycle on the first such sample only.
- R4: When `cs_n` and `iorq_n` are sampled low with `rd_n` and `m1_n` high, `data_i` of the first such sample is stored in the selected register and is visible on `regs_o` after the second rising edge.
- R5: One write access produces exactly one one-cycle `wr_stb` pulse, however long the strobes stay asserted.
- R6: If `m1_n` is sampled low with `iorq_n` and `rd_n` high on two consecutive edges (`cs_n` does not matter), all four registers clear, the pending request clears, `soft_rst` pulses once for one cycle and `data_oe` is low. A single low sample does nothing.
- R7: A cycle with `m1_n` and `iorq_n` both low is an interrupt acknowledge. It never raises `rd_stb`, `wr_stb` or `data_oe`, and never changes a register. `ack_o` pulses for one cycle only if `ie_in` was high and a request was pending, and that pulse clears the pending request.
- R8: `ie_out` equals `ie_in` AND NOT pending, combinationally from `ie_in`.
- R9: `irq_req` high at a rising edge sets the pending request, which then holds until cleared as in R6 or R7.
- R10: After `rd_n` returns high, `data_oe` stays high for one more cycle and drops at the second rising edge after the change.
- R11: While `rst_n` is low, all registers, strobes, `data_oe`, `ack_o` and `soft_rst` are zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | First machine cycle strobe, active low |
| port_sel | input | 1 | 0 selects port A, 1 selects port B |
| ctl_sel | input | 1 | 0 selects data register, 1 selects control register |
| data_i | input | DATA_W | Data bus value seen from the CPU |
| data_o | output | DATA_W | Value driven onto the data bus |
| data_oe | output | 1 | Data bus output enable |
| irq_req | input | 1 | Local interrupt request from the port logic |
| ie_in | input | 1 | Priority enable from the higher-priority neighbour |
| ie_out | output | 1 | Priority enable to the lower-priority neighbour |
| ack_o | output | 1 | One-cycle interrupt acknowledge grant |
| rd_stb | output | 4 | One-hot register read strobe |
| wr_stb | output | 4 | One-hot register write strobe |
| soft_rst | output | 1 | One-cycle pulse when the strobe-driven reset fires |
| regs_o | output | 4*DATA_W | Contents of the four registers |

## Verification
The bench builds the block with the default 8-bit data path and a two-sample reset threshold. With these values the bench can drive a one-sample M1 pulse that falls just short of the threshold, and a three-sample pulse that passes it and must still yield a single reset pulse. An 8-bit path keeps the four-register layout on `regs_o` at 32 bits. The bench can then compare the whole register file against exact words after each write, ignored write, acknowledge and reset.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    typedef struct packed {
        logic cs_n;
        logic iorq_n;
        logic rd_n;
        logic m1_n;
        logic port_sel;
        logic ctl_sel;
        logic ie_in;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{
        cs_n: 1'b1, iorq_n: 1'b1, rd_n: 1'b1, m1_n: 1'b1,
        port_sel: 1'b0, ctl_sel: 1'b0, ie_in: 1'b0
    };

    localparam int unsigned TGT_W     = 2;
    localparam int unsigned TGT_COUNT = 1 << TGT_W;

    typedef enum logic [TGT_W-1:0] {
        TGT_A_DATA = 2'd0,
        TGT_A_CTRL = 2'd1,
        TGT_B_DATA = 2'd2,
        TGT_B_CTRL = 2'd3
    } tgt_e;

    function automatic tgt_e tgt_of(input bus_smp_t s);
        return tgt_e'({s.port_sel, s.ctl_sel});
    endfunction

endpackage

// File: rtl/pbf_sampler.sv
module pbf_sampler
    import pbf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_smp_t          bus_i,
    input  logic [DATA_W-1:0] data_i,
    output bus_smp_t          bus_q_o,
    output logic [DATA_W-1:0] data_q_o
);

    typedef struct packed {
        bus_smp_t          bus;
        logic [DATA_W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.bus  = bus_i;
        smp_d.data = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.bus  <= BUS_IDLE;
            smp_q.data <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign bus_q_o  = smp_q.bus;
    assign data_q_o = smp_q.data;

endmodule

// File: rtl/pbf_decode.sv
module pbf_decode
    import pbf_pkg::*;
#(
    parameter int RST_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t smp_i,
    output logic     rd_act_o,
    output logic     rd_new_o,
    output logic     wr_new_o,
    output logic     ack_ok_o,
    output logic     srst_fire_o,
    output tgt_e     tgt_o
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic             held_rd;
        logic             held_wr;
        logic             held_ack;
        logic [CNT_W-1:0] m1_run;
    } dec_t;

    dec_t dec_d, dec_q;

    logic rd_act, wr_act, ack_act, rst_cond;

    always_comb begin
        rd_act   = !smp_i.cs_n && !smp_i.iorq_n && !smp_i.rd_n && smp_i.m1_n;
        wr_act   = !smp_i.cs_n && !smp_i.iorq_n &&  smp_i.rd_n && smp_i.m1_n;
        ack_act  = !smp_i.m1_n && !smp_i.iorq_n;
        rst_cond = !smp_i.m1_n &&  smp_i.iorq_n &&  smp_i.rd_n;

        dec_d          = dec_q;
        dec_d.held_rd  = rd_act;
        dec_d.held_wr  = wr_act;
        dec_d.held_ack = ack_act;
        if (!rst_cond)
            dec_d.m1_run = '0;
        else if (dec_q.m1_run != CNT_W'(RST_CYCLES))
            dec_d.m1_run = dec_q.m1_run + 1'b1;

        rd_act_o    = rd_act;
        rd_new_o    = rd_act && !dec_q.held_rd;
        wr_new_o    = wr_act && !dec_q.held_wr;
        ack_ok_o    = ack_act && !dec_q.held_ack && smp_i.ie_in;
        srst_fire_o = rst_cond && (dec_q.m1_run == CNT_W'(RST_CYCLES - 1));
        tgt_o       = tgt_of(smp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

endmodule

// File: rtl/pbf_regbank.sv
module pbf_regbank #(
    parameter int DATA_W  = 8,
    parameter int NUM_REG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REG-1:0]        wr_en_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      clr_i,
    output logic [NUM_REG*DATA_W-1:0] regs_o
);

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (clr_i)
                val_d = '0;
            else if (wr_en_i[g])
                val_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_o[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/pbf_intchain.sv
module pbf_intchain (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic ack_ok_i,
    input  logic clr_i,
    input  logic ie_in_i,
    output logic ie_out_o,
    output logic ack_o
);

    typedef struct packed {
        logic pend;
        logic ack;
    } ic_t;

    ic_t ic_d, ic_q;
    logic grant;

    always_comb begin
        grant  = ack_ok_i && ic_q.pend;
        ic_d   = ic_q;
        ic_d.ack = grant && !clr_i;
        if (clr_i || grant)
            ic_d.pend = 1'b0;
        else if (irq_req_i)
            ic_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ic_q <= '0;
        else        ic_q <= ic_d;
    end

    assign ie_out_o = ie_in_i && !ic_q.pend;
    assign ack_o    = ic_q.ack;

endmodule

// File: rtl/pbf_front.sv
module pbf_front
    import pbf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_CYCLES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        iorq_n,
    input  logic                        rd_n,
    input  logic                        m1_n,
    input  logic                        port_sel,
    input  logic                        ctl_sel,
    input  logic [DATA_W-1:0]           data_i,
    output logic [DATA_W-1:0]           data_o,
    output logic                        data_oe,
    input  logic                        irq_req,
    input  logic                        ie_in,
    output logic                        ie_out,
    output logic                        ack_o,
    output logic [TGT_COUNT-1:0]        rd_stb,
    output logic [TGT_COUNT-1:0]        wr_stb,
    output logic                        soft_rst,
    output logic [TGT_COUNT*DATA_W-1:0] regs_o
);

    typedef struct packed {
        logic                 oe;
        logic [DATA_W-1:0]    dout;
        logic [TGT_COUNT-1:0] rd;
        logic [TGT_COUNT-1:0] wr;
        logic                 srst;
    } out_t;

    bus_smp_t             bus_now, bus_q;
    logic [DATA_W-1:0]    data_q;
    logic                 rd_act, rd_new, wr_new, ack_ok, srst_fire;
    tgt_e                 tgt;
    logic [TGT_COUNT-1:0] tgt_hot, wr_en;
    logic [DATA_W-1:0]    sel_word;
    out_t                 out_d, out_q;

    always_comb begin
        bus_now          = BUS_IDLE;
        bus_now.cs_n     = cs_n;
        bus_now.iorq_n   = iorq_n;
        bus_now.rd_n     = rd_n;
        bus_now.m1_n     = m1_n;
        bus_now.port_sel = port_sel;
        bus_now.ctl_sel  = ctl_sel;
        bus_now.ie_in    = ie_in;
    end

    pbf_sampler #(.DATA_W(DATA_W)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_i    (bus_now),
        .data_i   (data_i),
        .bus_q_o  (bus_q),
        .data_q_o (data_q)
    );

    pbf_decode #(.RST_CYCLES(RST_CYCLES)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (bus_q),
        .rd_act_o    (rd_act),
        .rd_new_o    (rd_new),
        .wr_new_o    (wr_new),
        .ack_ok_o    (ack_ok),
        .srst_fire_o (srst_fire),
        .tgt_o       (tgt)
    );

    always_comb begin
        tgt_hot  = TGT_COUNT'(1) << tgt;
        wr_en    = wr_new ? tgt_hot : '0;
        sel_word = regs_o[int'(tgt)*DATA_W +: DATA_W];

        out_d      = out_q;
        out_d.oe   = rd_act && !srst_fire;
        out_d.dout = rd_act ? sel_word : '0;
        out_d.rd   = rd_new ? tgt_hot : '0;
        out_d.wr   = wr_en;
        out_d.srst = srst_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    pbf_regbank #(.DATA_W(DATA_W), .NUM_REG(TGT_COUNT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (data_q),
        .clr_i     (srst_fire),
        .regs_o    (regs_o)
    );

    pbf_intchain u_ic (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (irq_req),
        .ack_ok_i  (ack_ok),
        .clr_i     (srst_fire),
        .ie_in_i   (ie_in),
        .ie_out_o  (ie_out),
        .ack_o     (ack_o)
    );

    assign data_oe  = out_q.oe;
    assign data_o   = out_q.dout;
    assign rd_stb   = out_q.rd;
    assign wr_stb   = out_q.wr;
    assign soft_rst = out_q.srst;

endmodule

module pbf_front_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                iorq_n,
    input logic                rd_n,
    input logic                m1_n,
    input logic                ie_in,
    input logic                ie_out,
    input logic                ack_o,
    input logic                data_oe,
    input logic                soft_rst,
    input logic [3:0]          rd_stb,
    input logic [3:0]          wr_stb,
    input logic [4*DATA_W-1:0] regs_o
);

    // R3
    oe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!cs_n && !iorq_n && !rd_n && m1_n, 2));

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 2) |-> (wr_stb == '0 && rd_stb == '0 && !data_oe));

    // R1
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb) && $onehot0(rd_stb));

    // R5
    single_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |=> (wr_stb == '0));

    // R6
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (regs_o == '0 && !data_oe && ie_out == ie_in));

    // R6
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R7
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (wr_stb == '0 && rd_stb == '0 && !data_oe));

    // R8
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_out |-> ie_in);

endmodule

bind pbf_front pbf_front_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pbf_front_test.sv
`timescale 1ns/1ps
module pbf_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic        port_sel = 1'b0, ctl_sel = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic [7:0]  data_o;
    logic        data_oe;
    logic        irq_req = 1'b0, ie_in = 1'b1;
    logic        ie_out, ack_o, soft_rst;
    logic [3:0]  rd_stb, wr_stb;
    logic [31:0] regs_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int wr_pulses = 0, ack_pulses = 0, srst_pulses = 0;

    always #5 clk = ~clk;

    pbf_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .port_sel(port_sel), .ctl_sel(ctl_sel), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe), .irq_req(irq_req), .ie_in(ie_in),
        .ie_out(ie_out), .ack_o(ack_o), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .soft_rst(soft_rst), .regs_o(regs_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // behavioural reference model
    bit       s_cs = 1, s_iorq = 1, s_rd = 1, s_m1 = 1, s_ps = 0, s_cd = 0, s_ie = 0;
    bit [7:0] s_d = 0;
    bit       h_rd = 0, h_wr = 0, h_ack = 0, pend = 0;
    int       m1_run = 0;
    bit [7:0] mreg [4] = '{default: 8'h00};
    bit       e_oe = 0, e_ack = 0, e_srst = 0;
    bit [7:0] e_do = 0;
    bit [3:0] e_rd = 0, e_wr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            s_cs = 1; s_iorq = 1; s_rd = 1; s_m1 = 1; s_ps = 0; s_cd = 0; s_ie = 0; s_d = 0;
            h_rd = 0; h_wr = 0; h_ack = 0; pend = 0; m1_run = 0;
            foreach (mreg[i]) mreg[i] = 8'h00;
            e_oe = 0; e_ack = 0; e_srst = 0; e_do = 0; e_rd = 0; e_wr = 0;
        end else begin
            bit ra, wa, aa, rc, fire, grant;
            int idx;
            ra = !s_cs && !s_iorq && !s_rd && s_m1;
            wa = !s_cs && !s_iorq && s_rd && s_m1;
            aa = !s_m1 && !s_iorq;
            rc = !s_m1 && s_iorq && s_rd;
            idx = s_ps * 2 + s_cd;
            fire = rc && (m1_run == 1);
            grant = aa && !h_ack && s_ie && pend;
            e_rd = (ra && !h_rd) ? 4'(1 << idx) : 4'h0;
            e_wr = (wa && !h_wr) ? 4'(1 << idx) : 4'h0;
            e_oe = ra && !fire;
            e_do = ra ? mreg[idx] : 8'h00;
            e_srst = fire;
            e_ack = grant && !fire;
            if (fire || grant) pend = 0;
            else if (irq_req) pend = 1;
            if (fire) foreach (mreg[i]) mreg[i] = 8'h00;
            else if (wa && !h_wr) mreg[idx] = s_d;
            h_rd = ra; h_wr = wa; h_ack = aa;
            m1_run = rc ? ((m1_run < 2) ? m1_run + 1 : 2) : 0;
            s_cs = cs_n; s_iorq = iorq_n; s_rd = rd_n; s_m1 = m1_n;
            s_ps = port_sel; s_cd = ctl_sel; s_ie = ie_in; s_d = data_i;
        end
    end

    always @(negedge clk) begin
        #1;
        check("R4 register file", regs_o, {mreg[3], mreg[2], mreg[1], mreg[0]});
        check("R3 read strobe", {28'h0, rd_stb}, {28'h0, e_rd});
        check("R5 write strobe", {28'h0, wr_stb}, {28'h0, e_wr});
        check("R3 output enable", {31'h0, data_oe}, {31'h0, e_oe});
        check("R3 read data", {24'h0, data_o}, {24'h0, e_do});
        check("R6 soft reset", {31'h0, soft_rst}, {31'h0, e_srst});
        check("R7 acknowledge", {31'h0, ack_o}, {31'h0, e_ack});
        check("R8 chain out", {31'h0, ie_out}, {31'h0, ie_in && !pend});
        if (rst_n && wr_stb != 0) wr_pulses++;
        if (rst_n && ack_o) ack_pulses++;
        if (rst_n && soft_rst) srst_pulses++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cs_n = 1; iorq_n = 1; rd_n = 1; m1_n = 1;
        end
    endtask

    task automatic bus_wr(input bit ps, input bit cd, input logic [7:0] v, input int hold, input bit cs);
        @(negedge clk);
        cs_n = cs; iorq_n = 0; rd_n = 1; m1_n = 1; port_sel = ps; ctl_sel = cd; data_i = v;
        repeat (hold - 1) @(negedge clk);
        idle(3);
    endtask

    task automatic bus_rd(input bit ps, input bit cd, input int hold, input bit cs);
        @(negedge clk);
        cs_n = cs; iorq_n = 0; rd_n = 0; m1_n = 1; port_sel = ps; ctl_sel = cd;
        repeat (hold - 1) @(negedge clk);
        idle(3);
    endtask

    task automatic m1_pulse(input int len, input bit rd_lvl, input bit iorq_lvl);
        @(negedge clk);
        m1_n = 0; iorq_n = iorq_lvl; rd_n = rd_lvl;
        repeat (len - 1) @(negedge clk);
        idle(3);
    endtask

    task automatic irq_pulse();
        @(negedge clk); irq_req = 1;
        @(negedge clk); irq_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset regs", regs_o, 32'h0);
        check("R11 reset oe", {31'h0, data_oe}, 32'h0);
        check("R11 reset chain", {31'h0, ie_out}, 32'h1);
        @(negedge clk); rst_n = 1;
        idle(2);

        bus_wr(0, 0, 8'h11, 1, 0);
        bus_wr(0, 1, 8'h22, 2, 0);
        bus_wr(1, 0, 8'h33, 1, 0);
        bus_wr(1, 1, 8'h44, 1, 0);
        #1 check("R1 target map", regs_o, 32'h44332211);

        wr_pulses = 0;
        bus_wr(0, 0, 8'h5A, 6, 0);
        #1 check("R5 one pulse for long write", wr_pulses, 1);
        check("R4 long write data", regs_o, 32'h4433225A);

        bus_wr(0, 0, 8'hEE, 3, 1);
        #1 check("R2 cs high write ignored", regs_o, 32'h4433225A);
        bus_rd(1, 1, 3, 1);
        bus_rd(0, 1, 2, 0);

        // R3 / R10 directed read timing on port B data
        @(negedge clk);
        cs_n = 0; iorq_n = 0; rd_n = 0; m1_n = 1; port_sel = 1; ctl_sel = 0;
        @(negedge clk);
        #1 check("R3 oe not yet", {31'h0, data_oe}, 32'h0);
        @(negedge clk);
        #1 check("R3 oe high", {31'h0, data_oe}, 32'h1);
        check("R3 read value", {24'h0, data_o}, 32'h33);
        rd_n = 1; iorq_n = 1; cs_n = 1;
        @(negedge clk);
        #1 check("R10 oe held one cycle", {31'h0, data_oe}, 32'h1);
        @(negedge clk);
        #1 check("R10 oe released", {31'h0, data_oe}, 32'h0);
        idle(2);

        // interrupt chain
        irq_pulse();
        #1 check("R9 pending blocks chain", {31'h0, ie_out}, 32'h0);
        ack_pulses = 0;
        @(negedge clk); ie_in = 0;
        m1_pulse(2, 0, 0);
        @(negedge clk); ie_in = 1;
        #1 check("R7 no grant with ie_in low", ack_pulses, 0);
        check("R7 pending kept", {31'h0, ie_out}, 32'h0);
        cs_n = 0;
        m1_pulse(2, 0, 0);
        #1 check("R7 one grant", ack_pulses, 1);
        check("R8 chain reopened", {31'h0, ie_out}, 32'h1);
        check("R7 regs untouched", regs_o, 32'h4433225A);

        // M1 reset
        irq_pulse();
        srst_pulses = 0;
        m1_pulse(1, 1, 1);
        #1 check("R6 lone sample ignored", regs_o, 32'h4433225A);
        check("R6 lone sample no pulse", srst_pulses, 0);
        m1_pulse(3, 1, 1);
        #1 check("R6 regs cleared", regs_o, 32'h0);
        check("R6 pending cleared", {31'h0, ie_out}, 32'h1);
        check("R6 single pulse", srst_pulses, 1);

        bus_wr(1, 0, 8'hC3, 1, 0);
        bus_rd(1, 0, 2, 0);
        #1 check("R4 write after reset", regs_o, 32'h00C30000);
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule